// File: doc/BRIEF.md
# Split-Transaction Outstanding Request Tracker

This block keeps the list of memory transactions that have been requested but not yet answered on a snooping bus whose requests and responses travel on separate wires. Each agent on the bus holds an identical copy and updates it only from what it sees on the bus, so all copies stay the same. When a request is accepted, the block claims a free slot and the slot number becomes the short tag that the later response carries instead of the full line address. The response side then only has to select one slot by its number rather than compare an address against every slot.

Incoming requests are compared against all pending line addresses in the same cycle. A plain read to a line that already has a pending plain read is not sent again: the newcomer is recorded as a sharer of that slot and will take the data when the response appears. Any other collision on a pending line, and any new request while every slot is in use, is refused with a NACK so the requester retries later rather than stalling the bus. A response is only taken when the agent that opened the slot signals readiness; otherwise it is refused and the responder tries again. Accepted responses free their slot in that same cycle, and a slot freed this way may be handed to a request arriving in the very same cycle.

Top module: `split_txn_tracker`

## Requirements
- R1: After reset every slot is free, no response is accepted, and the first granted request receives tag 0.
- R2: A request to a line with no pending slot, while a slot is free, is granted (`req_ack`) and given the lowest-numbered free slot; that number appears on `req_tag`.
- R3: When every slot is in use and none is retiring in that cycle, a request that does not join is refused (`req_nack`) and no slot changes; a valid request always yields exactly one of grant, join or refusal.
- R4: A read (`req_kind` 2'b00) to a line whose pending slot was opened by a read joins that slot (`req_join`), returns that slot's number on `req_tag` and adds the requester to the slot's sharer set without taking a new slot.
- R5: Any request that meets a pending slot on the same line is refused unless it is a read meeting a read; read-exclusive is 2'b01, write is 2'b10, and 2'b11 is treated as a write.
- R6: A response (`rsp_valid`, `rsp_tag`) to a pending slot whose opening agent has its bit of `rsp_ready` set is accepted (`rsp_accept`), frees the slot, and drives `rsp_share_mask` with one bit per agent for the opener and every joiner; the mask is zero in any other cycle.
- R7: A response to a pending slot whose opening agent is not ready raises `rsp_nack` and leaves the slot pending; readiness of other agents does not matter.
- R8: A response that names a free slot raises neither `rsp_accept` nor `rsp_nack` and changes nothing.
- R9: A slot retired by an accepted response is available to a request in the same cycle, so a full table still grants when one slot is retiring.
- R10: A slot retiring in the current cycle is not matched by a request in that cycle; a request to its line is treated as a fresh request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is on the request bus this cycle |
| req_agent | input | $clog2(AGENTS) | Number of the requesting agent |
| req_kind | input | 2 | 00 read, 01 read-exclusive, 10 write, 11 treated as write |
| req_line | input | LINE_W | Line address of the request |
| req_ack | output | 1 | Request granted, new slot claimed |
| req_join | output | 1 | Request merged into a pending read slot |
| req_nack | output | 1 | Request refused, retry later |
| req_tag | output | $clog2(ENTRIES) | Slot number for a grant or join |
| rsp_valid | input | 1 | A response is on the response tag bus |
| rsp_tag | input | $clog2(ENTRIES) | Slot number the response answers |
| rsp_ready | input | AGENTS | Readiness of each agent to take data |
| rsp_accept | output | 1 | Response taken, slot freed |
| rsp_nack | output | 1 | Response refused, opener not ready |
| rsp_share_mask | output | AGENTS | Agents that capture the accepted response |

## Verification
The two functions that can land on one clock edge are retiring a slot through an accepted response and handling a new request. The bench fills the table and, in the cycle it sends an accepted response, issues a request: once to an unrelated line, where the grant must take exactly the retiring slot number, and once to the retiring slot's own line, where the request must not join the dying slot but open a fresh one. Later joins and responses on that fresh slot confirm which agents it records.

// File: rtl/split_txn_tracker.sv
module split_txn_tracker #(
  parameter int ENTRIES = 8,
  parameter int AGENTS  = 4,
  parameter int LINE_W  = 26
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic [$clog2(AGENTS)-1:0]  req_agent,
  input  logic [1:0]                 req_kind,
  input  logic [LINE_W-1:0]          req_line,
  output logic                       req_ack,
  output logic                       req_join,
  output logic                       req_nack,
  output logic [$clog2(ENTRIES)-1:0] req_tag,
  input  logic                       rsp_valid,
  input  logic [$clog2(ENTRIES)-1:0] rsp_tag,
  input  logic [AGENTS-1:0]          rsp_ready,
  output logic                       rsp_accept,
  output logic                       rsp_nack,
  output logic [AGENTS-1:0]          rsp_share_mask
);
  localparam int TAG_W = $clog2(ENTRIES);
  localparam int AG_W  = $clog2(AGENTS);

  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] excl_q;
  logic [LINE_W-1:0]  line_q  [ENTRIES];
  logic [AG_W-1:0]    owner_q [ENTRIES];
  logic [AGENTS-1:0]  share_q [ENTRIES];

  logic [ENTRIES-1:0] retire, hit, avail;
  logic               hit_any, free_any;
  logic [TAG_W-1:0]   hit_idx, alloc_idx;
  logic               req_is_rd, rsp_hit, owner_rdy;

  assign rsp_hit    = rsp_valid & valid_q[rsp_tag];
  assign owner_rdy  = rsp_ready[owner_q[rsp_tag]];
  assign rsp_accept = rsp_hit & owner_rdy;
  assign rsp_nack   = rsp_hit & ~owner_rdy;
  assign rsp_share_mask = rsp_accept ? share_q[rsp_tag] : '0;
  assign retire     = rsp_accept ? (ENTRIES'(1) << rsp_tag) : '0;
  assign avail      = ~valid_q | retire;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_match
    assign hit[g] = valid_q[g] & ~retire[g] & (line_q[g] == req_line);
  end

  always_comb begin
    hit_any = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hit[i]) begin
        hit_any = 1'b1;
        hit_idx = TAG_W'(i);
      end
  end

  always_comb begin
    free_any  = 1'b0;
    alloc_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (avail[i]) begin
        free_any  = 1'b1;
        alloc_idx = TAG_W'(i);
      end
  end

  assign req_is_rd = (req_kind == 2'b00);
  assign req_join  = req_valid & hit_any & req_is_rd & ~excl_q[hit_idx];
  assign req_ack   = req_valid & ~hit_any & free_any;
  assign req_nack  = req_valid & ~req_join & ~req_ack;
  assign req_tag   = hit_any ? hit_idx : alloc_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      excl_q  <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        line_q[i]  <= '0;
        owner_q[i] <= '0;
        share_q[i] <= '0;
      end
    end else begin
      if (rsp_accept) valid_q[rsp_tag] <= 1'b0;
      if (req_ack) begin
        valid_q[alloc_idx] <= 1'b1;
        excl_q[alloc_idx]  <= ~req_is_rd;
        line_q[alloc_idx]  <= req_line;
        owner_q[alloc_idx] <= req_agent;
        share_q[alloc_idx] <= AGENTS'(1) << req_agent;
      end
      if (req_join) share_q[hit_idx][req_agent] <= 1'b1;
    end
  end

  assert_alloc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> valid_q[$past(req_tag)]);

  assert_full_refuse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (&valid_q) && !rsp_accept) |-> !req_ack);

  assert_one_outcome_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $onehot({req_ack, req_join, req_nack}));

  assert_join_mark_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_join |=> share_q[$past(req_tag)][$past(req_agent)]);

  assert_retire_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_accept && !(req_ack && req_tag == rsp_tag)) |=> !valid_q[$past(rsp_tag)]);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_nack |=> valid_q[$past(rsp_tag)]);

  assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_accept && !rsp_nack && rsp_share_mask == '0));
endmodule

// File: tb/tb_split_txn_tracker.sv
module tb_split_txn_tracker;
  localparam int ENT = 4, AG = 4, LW = 26;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          req_valid = 0;
  logic [1:0]    req_agent = 0, req_kind = 0;
  logic [LW-1:0] req_line = 0;
  logic          req_ack, req_join, req_nack;
  logic [1:0]    req_tag;
  logic          rsp_valid = 0;
  logic [1:0]    rsp_tag = 0;
  logic [AG-1:0] rsp_ready = 0;
  logic          rsp_accept, rsp_nack;
  logic [AG-1:0] rsp_share_mask;

  split_txn_tracker #(.ENTRIES(ENT), .AGENTS(AG), .LINE_W(LW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_agent(req_agent),
    .req_kind(req_kind), .req_line(req_line), .req_ack(req_ack),
    .req_join(req_join), .req_nack(req_nack), .req_tag(req_tag),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_ready(rsp_ready),
    .rsp_accept(rsp_accept), .rsp_nack(rsp_nack), .rsp_share_mask(rsp_share_mask));

  typedef struct {
    int rq;
    logic ack, jn, nk;
    logic [1:0] tag;
    logic acc, rnk;
    logic [AG-1:0] mask;
  } exp_t;
  exp_t sb[$];
  int checks = 0, errors = 0;
  bit done = 0;

  localparam logic [1:0] RD = 2'b00, RX = 2'b01, WR = 2'b10;

  task automatic cyc(input int rq, input logic rv, input logic [1:0] ag, input logic [1:0] kd,
                     input logic [LW-1:0] ln, input logic sv, input logic [1:0] st,
                     input logic [AG-1:0] rdy, input logic e_ack, input logic e_jn,
                     input logic e_nk, input logic [1:0] e_tag, input logic e_acc,
                     input logic e_rnk, input logic [AG-1:0] e_mask);
    exp_t e;
    @(negedge clk);
    req_valid = rv; req_agent = ag; req_kind = kd; req_line = ln;
    rsp_valid = sv; rsp_tag = st; rsp_ready = rdy;
    e.rq = rq; e.ack = e_ack; e.jn = e_jn; e.nk = e_nk; e.tag = e_tag;
    e.acc = e_acc; e.rnk = e_rnk; e.mask = e_mask;
    sb.push_back(e);
  endtask

  always @(negedge clk) begin
    #1;
    if (sb.size() != 0) begin
      exp_t e;
      logic [1:0] act_tag;
      e = sb.pop_front();
      act_tag = (e.ack || e.jn) ? req_tag : e.tag;
      checks++;
      if ({req_ack, req_join, req_nack, act_tag, rsp_accept, rsp_nack, rsp_share_mask} !==
          {e.ack, e.jn, e.nk, e.tag, e.acc, e.rnk, e.mask}) begin
        errors++;
        $display("FAIL R%0d ack/join/nack/tag/acc/rnack/mask actual %b%b%b %0d %b%b %b expected %b%b%b %0d %b%b %b",
                 e.rq, req_ack, req_join, req_nack, act_tag, rsp_accept, rsp_nack, rsp_share_mask,
                 e.ack, e.jn, e.nk, e.tag, e.acc, e.rnk, e.mask);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    //   rq rv ag kd  line  sv st rdy     ack jn nk tag acc rnk mask
    cyc(1, 0, 0, RD, 'h0,  0, 0, 4'h0,   0, 0, 0, 0,  0, 0, 4'h0);  // R1 idle after reset
    cyc(1, 1, 0, RD, 'h10, 0, 0, 4'h0,   1, 0, 0, 0,  0, 0, 4'h0);  // R1 first grant tag 0
    cyc(4, 1, 1, RD, 'h10, 0, 0, 4'h0,   0, 1, 0, 0,  0, 0, 4'h0);  // R4 read joins read
    cyc(5, 1, 2, WR, 'h10, 0, 0, 4'h0,   0, 0, 1, 0,  0, 0, 4'h0);  // R5 write vs read refused
    cyc(2, 1, 1, RX, 'h20, 0, 0, 4'h0,   1, 0, 0, 1,  0, 0, 4'h0);  // R2 lowest free tag 1
    cyc(5, 1, 3, RD, 'h20, 0, 0, 4'h0,   0, 0, 1, 0,  0, 0, 4'h0);  // R5 read vs exclusive refused
    cyc(2, 1, 2, WR, 'h30, 0, 0, 4'h0,   1, 0, 0, 2,  0, 0, 4'h0);  // R2 tag 2
    cyc(2, 1, 3, RD, 'h40, 0, 0, 4'h0,   1, 0, 0, 3,  0, 0, 4'h0);  // R2 tag 3
    cyc(3, 1, 0, RD, 'h50, 0, 0, 4'h0,   0, 0, 1, 0,  0, 0, 4'h0);  // R3 full table refuses
    cyc(7, 0, 0, RD, 'h0,  1, 0, 4'hE,   0, 0, 0, 0,  0, 1, 4'h0);  // R7 opener not ready
    cyc(9, 1, 0, RD, 'h50, 1, 1, 4'h2,   1, 0, 0, 1,  1, 0, 4'h2);  // R9 retire tag1 + grant tag1
    cyc(10,1, 2, RD, 'h10, 1, 0, 4'h1,   1, 0, 0, 0,  1, 0, 4'h3);  // R10 fresh slot, R6 mask with joiner
    cyc(6, 0, 0, RD, 'h0,  1, 3, 4'h8,   0, 0, 0, 0,  1, 0, 4'h8);  // R6 retire tag 3
    cyc(8, 0, 0, RD, 'h0,  1, 3, 4'hF,   0, 0, 0, 0,  0, 0, 4'h0);  // R8 response to free slot ignored
    cyc(2, 1, 1, RD, 'h60, 0, 0, 4'h0,   1, 0, 0, 3,  0, 0, 4'h0);  // R2 only free slot 3
    cyc(10,1, 3, RD, 'h10, 0, 0, 4'h0,   0, 1, 0, 0,  0, 0, 4'h0);  // R10 new slot is a read slot
    cyc(10,0, 0, RD, 'h0,  1, 0, 4'h4,   0, 0, 0, 0,  1, 0, 4'hC);  // R10 opener is agent 2
    cyc(6, 0, 0, RD, 'h0,  1, 2, 4'h4,   0, 0, 0, 0,  1, 0, 4'h4);  // R6 retire tag 2
    cyc(2, 1, 0, WR, 'h70, 0, 0, 4'h0,   1, 0, 0, 0,  0, 0, 4'h0);  // R2 lowest of free 0 and 2
    cyc(5, 1, 1, RD, 'h70, 0, 0, 4'h0,   0, 0, 1, 0,  0, 0, 4'h0);  // R5 read vs write refused
    cyc(3, 0, 0, RD, 'h0,  0, 0, 4'h0,   0, 0, 0, 0,  0, 0, 4'h0);  // R3 idle, nothing asserted
    @(negedge clk);
    req_valid = 0; rsp_valid = 0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule